// File: doc/BRIEF.md
# SMBus Register Slave With Block Access

This block is a two-wire serial slave that owns a small bank of 8-bit control registers for a clock-generation subsystem. A system controller reaches the bank through single-byte transfers, where the command byte names one register, or through block transfers, which always begin at register 0 and climb upward one register per byte. The serial clock and data lines are sampled by a faster system clock, so the block needs no clock of its own from the bus.

The bank holds writable enable and mode bits that come up at fixed defaults, a read-only identification byte, and three read-only status bits. Those status bits take their value from a set of strap inputs captured once, on the first cycle a power-good input is seen high; later strap or power-good changes leave them alone. Every register is driven out in parallel on one wide vector, so the logic that uses the settings reads them directly. The data line is modelled as an input plus an active-high pull-low enable; the pad itself sits outside.

Top module: `smb_regbank`

## Requirements
- R1: The slave acknowledges the address byte D2h (write) and D3h (read), i.e. 7-bit address 1101001; any other address is left unacknowledged (SDA released during the 9th clock) and the transfer that follows changes no register.
- R2: A command byte with bit 7 = 1 selects single-byte mode and its bits 6:0 give the register offset; the one data byte that follows a write command is stored at that offset.
- R3: A single-byte read (address+W, command, repeated start, address+R) returns the register at the commanded offset, MSB first.
- R4: A command byte with bit 7 = 0 selects block mode; after a byte-count byte, each data byte is written to offsets 0, 1, 2 and upward in turn, and a stop after any complete byte leaves the higher offsets unchanged.
- R5: A block read (command 00h, repeated start, address+R) returns first the count 9, then registers 0, 1, 2 and upward for as long as the master acknowledges; a NACK ends the transfer and the slave sends nothing more until the next start.
- R6: After reset the registers hold: offset 0 = FFh, 1 = F6h, 2 = FFh, 3 = 00h, 4 = 07h, 5 = 00h, 6 = 18h with bits 2:0 showing the captured straps (000 before capture), 7 = 08h, 8 = 65h.
- R7: Offset 7 is read-only and always reads 08h (revision 0 in bits 7:4, vendor 8 in bits 3:0).
- R8: Bits 2:0 of offset 6 show strap_i as captured on the first clock with pgood_i high after reset; later strap_i changes and writes to those bits have no effect, while bits 7:3 of offset 6 stay writable.
- R9: Writes to offsets 9 and above are acknowledged and ignored; reads from them return 00h.
- R10: regs_o carries register k on bits [8k+7:8k].
- R11: The slave changes its SDA pull-low only while SCL is low, and releases SDA after a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 = slave pulls SDA low |
| pgood_i | input | 1 | Power-good; its first high captures the straps |
| strap_i | input | 3 | Frequency-select strap levels |
| regs_o | output | 72 | All registers, register k at bits [8k+7:8k] |

## Verification
The hardest state to reach is the middle of a block read that the master cuts short: the slave must stop driving after the NACK even though its pointer is mid-bank, and then answer a fresh single-byte read correctly. The bench drives a bit-level bus master against the open-drain line model, ends a block read after four data bytes, and immediately follows with a repeated-start byte read. Offsets past the bank and the read-only bits are reached by sweeping every offset 0 to 10 with single-byte writes and reads, and the strap capture is exercised by moving strap_i after power-good.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam int NREG      = 9;
    localparam int DW        = 8;
    localparam int STRAP_IDX = 6;
    localparam int ID_IDX    = 7;
    localparam logic [6:0] DEV_ADDR = 7'h69;

    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_ACKW, S_ACK, S_TX, S_MACK, S_MACKF, S_SKIP
    } sm_e;

    typedef enum logic [1:0] {
        P_ADDR, P_CMD, P_CNT, P_DATA
    } ph_e;

    function automatic logic [DW-1:0] rst_val(int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hF6;
            2:       return 8'hFF;
            4:       return 8'h07;
            6:       return 8'h18;
            7:       return 8'h08;
            8:       return 8'h65;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] ro_mask(int idx);
        case (idx)
            STRAP_IDX: return 8'h07;
            ID_IDX:    return 8'hFF;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbreg_filt.sv
module smbreg_filt #(
    parameter int W      = 2,
    parameter int STAGES = 2,
    parameter int FILT   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    localparam int CW = $clog2(FILT + 1);

    for (genvar b = 0; b < W; b++) begin : g_line
        logic [STAGES-1:0] sy_q;
        logic [CW-1:0]     cnt_q;
        logic              o_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sy_q  <= '1;
                cnt_q <= '0;
                o_q   <= 1'b1;
            end else begin
                sy_q <= {sy_q[STAGES-2:0], in_i[b]};
                if (sy_q[STAGES-1] != o_q) begin
                    if (cnt_q == CW'(FILT - 1)) begin
                        o_q   <= sy_q[STAGES-1];
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    cnt_q <= '0;
                end
            end
        end

        assign out_o[b] = o_q;
    end
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
    import smbreg_pkg::*;
#(
    parameter int N  = NREG,
    parameter int AW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            pgood_i,
    input  logic [2:0]      strap_i,
    output logic            strap_done_o,
    output logic [N*DW-1:0] regs_o
);
    logic [2:0] strap_q;
    logic       done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q <= '0;
            done_q  <= 1'b0;
        end else if (!done_q && pgood_i) begin
            strap_q <= strap_i;
            done_q  <= 1'b1;
        end
    end

    assign strap_done_o = done_q;

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [DW-1:0] RST = rst_val(g);
        localparam logic [DW-1:0] RO  = ro_mask(g);
        logic [DW-1:0] r_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= RST;
            end else if (wr_en && wr_addr == AW'(g)) begin
                r_q <= (wr_data & ~RO) | (r_q & RO);
            end
        end

        if (g == STRAP_IDX) begin : g_strap
            assign regs_o[g*DW +: DW] = (r_q & ~RO) | {5'b0, strap_q};
        end else begin : g_plain
            assign regs_o[g*DW +: DW] = r_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_addr == AW'(i)) rd_data = regs_o[i*DW +: DW];
        end
    end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smbreg_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe_o,
    input  logic            pgood_i,
    input  logic [2:0]      strap_i,
    output logic [N*DW-1:0] regs_o
);
    localparam int AW = 7;

    typedef struct packed {
        sm_e          sm;
        ph_e          ph;
        logic [2:0]   cnt;
        logic [7:0]   sh;
        logic         oe;
        logic [AW-1:0] ptr;
        logic         bytemode;
        logic         hdr;
        logic         rd;
        logic         scl_p;
        logic         sda_p;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]    filt_w;
    logic          scl_f, sda_f;
    logic          rise_w, fall_w, start_w, stop_w;
    logic          wr_en_w;
    logic [7:0]    rx_byte;
    logic [7:0]    rd_data_w;
    logic          strap_done_w;

    smbreg_filt #(.W(2), .STAGES(2), .FILT(3)) i_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({sda_i, scl_i}),
        .out_o (filt_w)
    );

    assign scl_f = filt_w[0];
    assign sda_f = filt_w[1];

    assign rise_w  = scl_f & ~st_q.scl_p;
    assign fall_w  = ~scl_f & st_q.scl_p;
    assign start_w = scl_f & st_q.scl_p & st_q.sda_p & ~sda_f;
    assign stop_w  = scl_f & st_q.scl_p & ~st_q.sda_p & sda_f;
    assign rx_byte = {st_q.sh[6:0], sda_f};

    smbreg_bank #(.N(N), .AW(AW)) i_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en_w),
        .wr_addr      (st_q.ptr),
        .wr_data      (rx_byte),
        .rd_addr      (st_q.ptr),
        .rd_data      (rd_data_w),
        .pgood_i      (pgood_i),
        .strap_i      (strap_i),
        .strap_done_o (strap_done_w),
        .regs_o       (regs_o)
    );

    always_comb begin
        st_d       = st_q;
        wr_en_w    = 1'b0;
        st_d.scl_p = scl_f;
        st_d.sda_p = sda_f;

        if (start_w) begin
            st_d.sm  = S_RX;
            st_d.ph  = P_ADDR;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
            st_d.rd  = 1'b0;
        end else if (stop_w) begin
            st_d.sm = S_IDLE;
            st_d.oe = 1'b0;
        end else begin
            case (st_q.sm)
                S_RX: if (rise_w) begin
                    st_d.sh  = rx_byte;
                    st_d.cnt = st_q.cnt + 3'd1;
                    if (st_q.cnt == 3'd7) begin
                        st_d.sm = S_ACKW;
                        case (st_q.ph)
                            P_ADDR: begin
                                if (rx_byte[7:1] != DEV_ADDR) st_d.sm = S_SKIP;
                                st_d.rd = rx_byte[0];
                                st_d.ph = P_CMD;
                            end
                            P_CMD: begin
                                st_d.bytemode = rx_byte[7];
                                st_d.ptr      = rx_byte[7] ? rx_byte[6:0] : '0;
                                st_d.ph       = rx_byte[7] ? P_DATA : P_CNT;
                            end
                            P_CNT: st_d.ph = P_DATA;
                            default: begin
                                wr_en_w  = 1'b1;
                                st_d.ptr = st_q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                S_ACKW: if (fall_w) begin
                    st_d.oe = 1'b1;
                    st_d.sm = S_ACK;
                end
                S_ACK: if (fall_w) begin
                    st_d.cnt = '0;
                    if (st_q.rd) begin
                        st_d.sh  = st_q.bytemode ? rd_data_w : 8'(N);
                        st_d.hdr = !st_q.bytemode;
                        st_d.oe  = st_q.bytemode ? ~rd_data_w[7] : ~N[7];
                        st_d.sm  = S_TX;
                    end else begin
                        st_d.oe = 1'b0;
                        st_d.sm = S_RX;
                    end
                end
                S_TX: if (fall_w) begin
                    if (st_q.cnt == 3'd7) begin
                        st_d.oe = 1'b0;
                        st_d.sm = S_MACK;
                    end else begin
                        st_d.sh  = {st_q.sh[6:0], 1'b0};
                        st_d.oe  = ~st_q.sh[6];
                        st_d.cnt = st_q.cnt + 3'd1;
                    end
                end
                S_MACK: if (rise_w) begin
                    if (!sda_f) begin
                        st_d.sm = S_MACKF;
                        if (!st_q.hdr) st_d.ptr = st_q.ptr + 1'b1;
                    end else begin
                        st_d.sm = S_SKIP;
                    end
                end
                S_MACKF: if (fall_w) begin
                    st_d.sh  = rd_data_w;
                    st_d.hdr = 1'b0;
                    st_d.oe  = ~rd_data_w[7];
                    st_d.cnt = '0;
                    st_d.sm  = S_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sm       <= S_IDLE;
            st_q.ph       <= P_ADDR;
            st_q.scl_p    <= 1'b1;
            st_q.sda_p    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o = st_q.oe;
endmodule

// File: rtl/smbreg_chk.sv
module smbreg_chk #(
    parameter int N = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_f,
    input logic           sda_oe,
    input logic           stop_ev,
    input logic           wr_en,
    input logic           strap_done,
    input logic [N*8-1:0] regs
);
    assert_id_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        regs[63:56] == 8'h08);

    assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    assert_sda_hold_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        scl_f |-> $stable(sda_oe));

    assert_strap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done |=> $stable(regs[50:48]));

    assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && strap_done) |=> $stable(regs));
endmodule

bind smb_regbank smbreg_chk #(.N(N)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_f),
    .sda_oe     (sda_oe_o),
    .stop_ev    (stop_w),
    .wr_en      (wr_en_w),
    .strap_done (strap_done_w),
    .regs       (regs_o)
);

// File: tb/test_smb_regbank.sv
module test_smb_regbank;
    localparam int NR = 9;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pgood = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] mdl [NR];

    always #2 clk = ~clk;

    smb_regbank i_smb_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .pgood_i  (pgood),
        .strap_i  (strap),
        .regs_o   (regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(int k);
        logic [7:0] t [NR] = '{8'hFF, 8'hF6, 8'hFF, 8'h00, 8'h07, 8'h00, 8'h18, 8'h08, 8'h65};
        return t[k];
    endfunction

    function automatic logic [7:0] romask(int k);
        return (k == 7) ? 8'hFF : (k == 6) ? 8'h07 : 8'h00;
    endfunction

    task automatic mdl_write(int k, logic [7:0] v);
        if (k < NR) mdl[k] = (v & ~romask(k)) | (mdl[k] & romask(k));
    endtask

    task automatic chk_regs(input string req);
        for (int k = 0; k < NR; k++) chk(req, 32'(regs[k*8 +: 8]), 32'(mdl[k]));
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; wq; scl_m = 1'b1; wq; r = sda_bus; wq; scl_m = 1'b0; wq;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic nack);
        logic x;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], x);
        clk_bit(1'b1, nack);
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) clk_bit(1'b1, d[i]);
        clk_bit(nack, x);
    endtask

    task automatic byte_write(input int off, input logic [7:0] v, input string req);
        logic a;
        bus_start;
        wr_byte(8'hD2, a);               chk({req, " addr ack R1"}, 32'(a), 0);
        wr_byte(8'h80 | 8'(off), a);     chk({req, " cmd ack R2"}, 32'(a), 0);
        wr_byte(v, a);                   chk({req, " data ack"}, 32'(a), 0);
        bus_stop;
        chk("R11 released after stop", 32'(sda_oe), 0);
    endtask

    task automatic byte_read(input int off, output logic [7:0] d);
        logic a;
        bus_start;
        wr_byte(8'hD2, a);
        wr_byte(8'h80 | 8'(off), a);
        bus_start;
        wr_byte(8'hD3, a);               chk("R1 read addr ack", 32'(a), 0);
        rd_byte(1'b1, d);
        bus_stop;
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        for (int k = 0; k < NR; k++) mdl[k] = dflt(k);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk_regs("R6 reset defaults");

        pgood = 1'b1;
        repeat (3) @(negedge clk);
        strap = 3'b010;
        pgood = 1'b0;
        repeat (3) @(negedge clk);
        mdl[6] = mdl[6] | 8'h05;
        chk("R8 strap captured once", 32'(regs[55:48]), 32'h1D);

        // R2 R9 R10: single-byte write sweep over every offset and two past the bank
        for (int off = 0; off < NR + 2; off++) begin
            logic [7:0] v;
            v = 8'h5A ^ 8'(off * 37);
            byte_write(off, v, "R9 R2 sweep");
            mdl_write(off, v);
            chk_regs("R10 R2 R7 R8 after byte write");
        end
        // R3 R7 R9: single-byte read sweep
        for (int off = 0; off < NR + 2; off++) begin
            byte_read(off, d);
            chk("R3 R9 byte read", 32'(d), (off < NR) ? 32'(mdl[off]) : 32'h0);
        end

        // R4: full block write
        bus_start;
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);               chk("R4 block cmd ack", 32'(a), 0);
        wr_byte(8'(NR), a);              chk("R4 count ack", 32'(a), 0);
        for (int k = 0; k < NR; k++) begin
            logic [7:0] v;
            v = 8'hC3 + 8'(k * 29);
            wr_byte(v, a);
            chk("R4 block data ack", 32'(a), 0);
            mdl_write(k, v);
        end
        bus_stop;
        chk_regs("R4 full block write");

        // R4: block write cut after three bytes
        bus_start;
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        wr_byte(8'(NR), a);
        for (int k = 0; k < 3; k++) begin
            wr_byte(8'h11 * 8'(k + 1), a);
            mdl_write(k, 8'h11 * 8'(k + 1));
        end
        bus_stop;
        chk_regs("R4 truncated block write");

        // R5: full block read
        bus_start;
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        bus_start;
        wr_byte(8'hD3, a);
        rd_byte(1'b0, d);                chk("R5 byte count", 32'(d), NR);
        for (int k = 0; k < NR; k++) begin
            rd_byte(k == NR - 1, d);
            chk("R5 block read data", 32'(d), 32'(mdl[k]));
        end
        bus_stop;

        // R5: block read cut after four data bytes, then a byte read
        bus_start;
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        bus_start;
        wr_byte(8'hD3, a);
        rd_byte(1'b0, d);
        for (int k = 0; k < 4; k++) begin
            rd_byte(k == 3, d);
            chk("R5 short block read", 32'(d), 32'(mdl[k]));
        end
        wq;
        chk("R5 silent after NACK", 32'(sda_oe), 0);
        bus_start;
        wr_byte(8'hD2, a);
        wr_byte(8'h88, a);
        bus_start;
        wr_byte(8'hD3, a);
        rd_byte(1'b1, d);
        bus_stop;
        chk("R5 R3 resync byte read", 32'(d), 32'(mdl[8]));

        // R1: foreign address ignored
        bus_start;
        wr_byte(8'hA4, a);               chk("R1 foreign addr NACK", 32'(a), 1);
        wr_byte(8'h81, a);
        wr_byte(8'h00, a);
        bus_stop;
        chk_regs("R1 no change on foreign address");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule